// File: doc/BRIEF.md
# Shared-Line Serial Transmitter with Collision Watch

This block serialises nine-bit words onto an asynchronous line that other stations may also drive, such as an open-drain or single-wire bus. Its receive input is tied to the same wire. While a frame is going out, the block compares the level it drives with the level it reads back. If the two differ at the chosen sample point, it raises a sticky collision request. Software can let that request withdraw the transmit enable, which cuts the frame short.

Sampling happens either on each transfer-clock enable pulse or on an external strobe, for example a one-shot timer underflow. A frame starts in one of two ways: a fixed one transfer clock after the send condition holds, or on an edge of the receive line so the frame lines up with another station. One polarity control inverts both the driven and the read-back wire. All internal logic works on logical levels.

Top module: `bctx_top`

## Requirements
- R1: A frame is one start bit at logical 0, then data bits D0 to D8 with the least significant bit first, then one stop bit at logical 1. Each bit is held from one transfer-clock enable to the next. Outside a frame the line rests at logical 1.
- R2: When `cfg_pol_inv` is 1, `txd_out` is the complement of the logical line and `rxd_in` is complemented before any use. The idle level on `txd_out` is then 0.
- R3: With `cfg_edge_start` at 0, the send condition is transmit enable set, a word pending and no frame in progress. Once it holds, the first following transfer-clock enable does not start a frame. The second one puts the start bit on the line.
- R4: With `cfg_edge_start` at 1, transfer-clock enables never start a frame. A falling edge of the logical receive level starts one: the start bit is on the line the cycle after that edge is sampled. This is a physical falling edge with normal polarity and a physical rising edge with inverted polarity.
- R5: In edge-start mode, an edge that arrives while the send condition is false is ignored, and a later enable alone does not start a frame.
- R6: With `cfg_samp_sel` at 0, the driven and read-back bits are compared only on transfer-clock enable cycles during a frame. `samp_strobe` has no effect.
- R7: With `cfg_samp_sel` at 1, the comparison happens only on `samp_strobe` cycles during a frame. Transfer-clock enables do not compare.
- R8: A mismatch sets `coll_flag` on the following cycle, and the flag stays set until it is cleared.
- R9: A pulse on `coll_clr` clears `coll_flag`. A mismatch in the same cycle wins, and the flag stays set.
- R10: With `cfg_auto_clr` at 1, a mismatch clears transmit enable on the next cycle. Whenever enable is low during a frame, the next transfer-clock enable aborts the frame and returns the line to idle.
- R11: With `cfg_auto_clr` at 0, a mismatch leaves transmit enable set and the frame runs to its stop bit.
- R12: After reset the line is idle, and transmit enable, the pending word, busy and the collision flag are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tclk_en | input | 1 | One-cycle pulse that marks a rising transfer-clock edge |
| samp_strobe | input | 1 | External comparison strobe, for example a timer underflow |
| rxd_in | input | 1 | Read-back of the shared line |
| txd_out | output | 1 | Driven line level, after polarity |
| cfg_pol_inv | input | 1 | 1 inverts both line directions |
| cfg_samp_sel | input | 1 | 0 compares on transfer clock, 1 compares on strobe |
| cfg_auto_clr | input | 1 | 1 lets a collision clear transmit enable |
| cfg_edge_start | input | 1 | 1 starts frames on a receive-line edge |
| te_set | input | 1 | Sets transmit enable |
| te_clr | input | 1 | Clears transmit enable |
| te_out | output | 1 | Current transmit enable |
| tx_load | input | 1 | Writes `tx_data` into the holding register |
| tx_data | input | 9 | Word to send |
| tx_pending | output | 1 | A loaded word waits to be sent |
| busy | output | 1 | A frame is on the line |
| coll_flag | output | 1 | Sticky collision request |
| coll_clr | input | 1 | Clears the collision request |

## Verification
Loopback frames are sent with all-zero, all-one, alternating and single-bit words under both polarities. These words separate bit-order, bit-count and inversion faults, and the table also pins down the two-enable start latency. Directed runs pull the read-back wire against the driven level. One run does so on a transfer-clock pulse and another on a strobe, which separates the two sample sources. Further runs cover auto-clear on and off, and a clear that coincides with a collision. In edge-start mode the bench applies edges of both directions under both polarities, with and without the send condition, so a wrong edge sense or a missing condition check shows as a frame that starts when it should not.

// File: rtl/bctx_pkg.sv
package bctx_pkg;

    // Logical line levels used throughout the datapath
    localparam logic LINE_IDLE = 1'b1;
    localparam logic LINE_START = 1'b0;
    localparam logic LINE_STOP = 1'b1;

    typedef struct packed {
        logic pol_inv;
        logic samp_sel;
        logic auto_clr;
        logic edge_start;
    } bctx_cfg_t;

    typedef enum logic {
        START_DELAYED = 1'b0,
        START_ON_EDGE = 1'b1
    } start_mode_e;

    // Map between logical level and wire level
    function automatic logic wire_level(input logic lvl, input logic inv);
        return lvl ^ inv;
    endfunction

    // High-to-low transition between two consecutive samples
    function automatic logic fell_between(input logic prev, input logic cur);
        return prev & ~cur;
    endfunction

endpackage

// File: rtl/bctx_ctrl.sv
module bctx_ctrl
    import bctx_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              te_set,
    input  logic              te_clr,
    input  logic              coll_kill,
    input  logic              tx_load,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              frame_go,
    output logic              te,
    output logic              pend,
    output logic [DATA_W-1:0] hold
);

    // Transmit enable: a collision kill outranks software writes
    always_ff @(posedge clk) begin
        if (rst) begin
            te <= 1'b0;
        end else if (coll_kill) begin
            te <= 1'b0;
        end else if (te_clr) begin
            te <= 1'b0;
        end else if (te_set) begin
            te <= 1'b1;
        end
    end

    // Holding register; a load in the start cycle refills it
    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
            hold <= '0;
        end else if (tx_load) begin
            pend <= 1'b1;
            hold <= tx_data;
        end else if (frame_go) begin
            pend <= 1'b0;
        end
    end

    p_kill_drops_te_r10: assert property (@(posedge clk) disable iff (rst)
        coll_kill |=> !te);

    p_te_set_holds_r11: assert property (@(posedge clk) disable iff (rst)
        (te_set && !te_clr && !coll_kill) |=> te);

endmodule

// File: rtl/bctx_start.sv
module bctx_start
    import bctx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tclk_en,
    input  logic edge_start,
    input  logic rx_logic,
    input  logic cond,
    output logic go
);

    start_mode_e mode;
    logic        rx_q;
    logic        armed;
    logic        rx_fall;

    assign mode    = edge_start ? START_ON_EDGE : START_DELAYED;
    assign rx_fall = fell_between(rx_q, rx_logic);

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q <= LINE_IDLE;
        end else begin
            rx_q <= rx_logic;
        end
    end

    // Delayed mode: first transfer clock with the condition arms, second starts
    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
        end else if (!cond || mode == START_ON_EDGE) begin
            armed <= 1'b0;
        end else if (tclk_en) begin
            armed <= 1'b1;
        end
    end

    always_comb begin
        unique case (mode)
            START_ON_EDGE: go = cond & rx_fall;
            default:       go = cond & armed & tclk_en;
        endcase
    end

    p_edge_needs_rxfall_r4: assert property (@(posedge clk) disable iff (rst)
        (go && edge_start) |-> ($past(rx_logic) && !rx_logic));

    p_delayed_on_tclk_r3: assert property (@(posedge clk) disable iff (rst)
        (go && !edge_start) |-> tclk_en);

endmodule

// File: rtl/bctx_shift.sv
module bctx_shift
    import bctx_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tclk_en,
    input  logic              go,
    input  logic              te,
    input  logic [DATA_W-1:0] data,
    output logic              busy,
    output logic              line_bit
);

    localparam int FRAME_W = DATA_W + 2;
    localparam int CNT_W = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);

    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            frame <= '1;
            idx   <= '0;
        end else if (go) begin
            busy  <= 1'b1;
            frame <= {LINE_STOP, data, LINE_START};
            idx   <= '0;
        end else if (busy && tclk_en) begin
            if (!te || idx == LAST_IDX) begin
                // abort on lost enable, or stop bit finished
                busy  <= 1'b0;
                frame <= '1;
                idx   <= '0;
            end else begin
                frame <= {LINE_IDLE, frame[FRAME_W-1:1]};
                idx   <= idx + 1'b1;
            end
        end
    end

    assign line_bit = busy ? frame[0] : LINE_IDLE;

    p_start_bit_first_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (line_bit == LINE_START));

    p_end_on_tclk_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(tclk_en));

    p_no_go_while_busy_r3: assert property (@(posedge clk) disable iff (rst)
        busy |-> !go);

endmodule

// File: rtl/bctx_coll.sv
module bctx_coll
    import bctx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tclk_en,
    input  logic samp_strobe,
    input  logic samp_sel,
    input  logic busy,
    input  logic line_bit,
    input  logic rx_logic,
    input  logic flag_clr,
    output logic mismatch,
    output logic flag
);

    logic sample_pt;

    assign sample_pt = samp_sel ? samp_strobe : tclk_en;
    assign mismatch  = sample_pt & busy & (line_bit != rx_logic);

    // Sticky request; a fresh collision outranks the clear
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (mismatch) begin
            flag <= 1'b1;
        end else if (flag_clr) begin
            flag <= 1'b0;
        end
    end

    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (flag && !flag_clr) |=> flag);

    p_rise_at_tclk_r6: assert property (@(posedge clk) disable iff (rst)
        ($rose(flag) && !$past(samp_sel)) |-> $past(tclk_en));

    p_rise_at_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        ($rose(flag) && $past(samp_sel)) |-> $past(samp_strobe));

    p_coll_beats_clr_r9: assert property (@(posedge clk) disable iff (rst)
        (mismatch && flag_clr) |=> flag);

endmodule

// File: rtl/bctx_top.sv
module bctx_top
    import bctx_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tclk_en,
    input  logic              samp_strobe,
    input  logic              rxd_in,
    output logic              txd_out,
    input  logic              cfg_pol_inv,
    input  logic              cfg_samp_sel,
    input  logic              cfg_auto_clr,
    input  logic              cfg_edge_start,
    input  logic              te_set,
    input  logic              te_clr,
    output logic              te_out,
    input  logic              tx_load,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_pending,
    output logic              busy,
    output logic              coll_flag,
    input  logic              coll_clr
);

    bctx_cfg_t         cfg;
    logic              rx_logic;
    logic              line_bit;
    logic              cond;
    logic              go;
    logic              mismatch;
    logic              te;
    logic              pend;
    logic [DATA_W-1:0] hold;

    assign cfg = '{pol_inv: cfg_pol_inv, samp_sel: cfg_samp_sel,
                   auto_clr: cfg_auto_clr, edge_start: cfg_edge_start};

    assign rx_logic = wire_level(rxd_in, cfg.pol_inv);
    assign txd_out  = wire_level(line_bit, cfg.pol_inv);
    assign cond     = te & pend & ~busy;

    bctx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .te_set    (te_set),
        .te_clr    (te_clr),
        .coll_kill (mismatch & cfg.auto_clr),
        .tx_load   (tx_load),
        .tx_data   (tx_data),
        .frame_go  (go),
        .te        (te),
        .pend      (pend),
        .hold      (hold)
    );

    bctx_start u_start (
        .clk        (clk),
        .rst        (rst),
        .tclk_en    (tclk_en),
        .edge_start (cfg.edge_start),
        .rx_logic   (rx_logic),
        .cond       (cond),
        .go         (go)
    );

    bctx_shift #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .tclk_en  (tclk_en),
        .go       (go),
        .te       (te),
        .data     (hold),
        .busy     (busy),
        .line_bit (line_bit)
    );

    bctx_coll u_coll (
        .clk         (clk),
        .rst         (rst),
        .tclk_en     (tclk_en),
        .samp_strobe (samp_strobe),
        .samp_sel    (cfg.samp_sel),
        .busy        (busy),
        .line_bit    (line_bit),
        .rx_logic    (rx_logic),
        .flag_clr    (coll_clr),
        .mismatch    (mismatch),
        .flag        (coll_flag)
    );

    assign te_out     = te;
    assign tx_pending = pend;

    p_idle_level_r2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (txd_out == (LINE_IDLE ^ cfg_pol_inv)));

    p_go_consumes_word_r3: assert property (@(posedge clk) disable iff (rst)
        ($rose(busy) && !$past(tx_load)) |-> !tx_pending);

endmodule

// File: tb/bctx_top_test.sv
module bctx_top_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tclk_en = 1'b0;
    logic       samp_strobe = 1'b0;
    logic       rxd_in;
    logic       txd_out;
    logic       cfg_pol_inv = 1'b0;
    logic       cfg_samp_sel = 1'b0;
    logic       cfg_auto_clr = 1'b0;
    logic       cfg_edge_start = 1'b0;
    logic       te_set = 1'b0;
    logic       te_clr = 1'b0;
    logic       te_out;
    logic       tx_load = 1'b0;
    logic [8:0] tx_data = '0;
    logic       tx_pending;
    logic       busy;
    logic       coll_flag;
    logic       coll_clr = 1'b0;

    logic       frc_en = 1'b0;
    logic       frc_val = 1'b0;
    int         n_chk = 0;
    int         n_bad = 0;

    // Wire model: loopback unless another station overrides the level
    assign rxd_in = frc_en ? frc_val : txd_out;

    always #4 clk = ~clk;

    bctx_top uut (
        .clk(clk), .rst(rst), .tclk_en(tclk_en), .samp_strobe(samp_strobe),
        .rxd_in(rxd_in), .txd_out(txd_out), .cfg_pol_inv(cfg_pol_inv),
        .cfg_samp_sel(cfg_samp_sel), .cfg_auto_clr(cfg_auto_clr),
        .cfg_edge_start(cfg_edge_start), .te_set(te_set), .te_clr(te_clr),
        .te_out(te_out), .tx_load(tx_load), .tx_data(tx_data),
        .tx_pending(tx_pending), .busy(busy), .coll_flag(coll_flag),
        .coll_clr(coll_clr)
    );

    // {polarity, word}
    localparam logic [9:0] VEC [6] = '{
        {1'b0, 9'h000}, {1'b0, 9'h1FF}, {1'b1, 9'h155},
        {1'b0, 9'h0AA}, {1'b1, 9'h100}, {1'b0, 9'h001}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One clock: inputs held across the posedge, then released
    task automatic step(input logic tc);
        tclk_en = tc;
        @(negedge clk);
        tclk_en = 1'b0;
    endtask

    task automatic tick();
        step(1'b1);
        step(1'b0);
    endtask

    task automatic load(input logic [8:0] d);
        tx_data = d;
        tx_load = 1'b1;
        step(1'b0);
        tx_load = 1'b0;
    endtask

    task automatic en_set();
        te_set = 1'b1;
        step(1'b0);
        te_set = 1'b0;
    endtask

    task automatic en_clr();
        te_clr = 1'b1;
        step(1'b0);
        te_clr = 1'b0;
    endtask

    task automatic flag_clear();
        coll_clr = 1'b1;
        step(1'b0);
        coll_clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        repeat (3) step(1'b0);
        rst = 1'b0;
        step(1'b0);

        // R12 reset state
        chk("R12 txd", {31'd0, txd_out}, 32'd1);
        chk("R12 busy/te/pend/flag", {28'd0, busy, te_out, tx_pending, coll_flag}, 32'd0);

        // Loopback frames from the table
        foreach (VEC[v]) begin
            logic       pol;
            logic [8:0] w;
            logic [10:0] got;
            logic [10:0] want;
            pol = VEC[v][9];
            w   = VEC[v][8:0];
            cfg_pol_inv = pol;
            step(1'b0);
            step(1'b0);
            load(w);
            en_set();
            step(1'b1);
            chk("R3 no start at first transfer clock", {31'd0, busy}, 32'd0);
            step(1'b0);
            for (int i = 0; i < 11; i++) begin
                step(1'b1);
                got[i] = txd_out;
                step(1'b0);
            end
            want = {1'b1, w, 1'b0} ^ {11{pol}};
            chk("R1 R2 frame bits", {21'd0, got}, {21'd0, want});
            step(1'b1);
            chk("R1 R2 idle after stop", {30'd0, busy, txd_out}, {31'd0, ~pol});
            chk("R6 no false collision", {31'd0, coll_flag}, 32'd0);
            step(1'b0);
            en_clr();
        end
        cfg_pol_inv = 1'b0;
        step(1'b0);

        // Collision on transfer clock, auto-clear on
        cfg_auto_clr = 1'b1;
        load(9'h1FF);
        en_set();
        tick(); tick(); tick();
        frc_en = 1'b1; frc_val = 1'b0;
        step(1'b0);
        chk("R6 strobe-less gap does not compare", {31'd0, coll_flag}, 32'd0);
        step(1'b1);
        frc_en = 1'b0;
        chk("R6 R8 flag on transfer clock", {31'd0, coll_flag}, 32'd1);
        chk("R10 enable cleared", {31'd0, te_out}, 32'd0);
        chk("R10 frame held until transfer clock", {31'd0, busy}, 32'd1);
        step(1'b0); step(1'b0);
        chk("R8 flag sticky", {31'd0, coll_flag}, 32'd1);
        step(1'b1);
        chk("R10 aborted to idle", {30'd0, busy, txd_out}, 32'd1);
        flag_clear();
        chk("R9 clear", {31'd0, coll_flag}, 32'd0);

        // Collision with auto-clear off: frame completes
        cfg_auto_clr = 1'b0;
        load(9'h1FF);
        en_set();
        tick(); tick(); tick();
        frc_en = 1'b1; frc_val = 1'b0;
        step(1'b1);
        frc_en = 1'b0;
        chk("R11 flag set", {31'd0, coll_flag}, 32'd1);
        chk("R11 enable kept", {31'd0, te_out}, 32'd1);
        step(1'b0);
        for (int k = 0; k < 8; k++) tick();
        chk("R11 still sending", {31'd0, busy}, 32'd1);
        tick();
        chk("R11 frame ran to stop", {31'd0, busy}, 32'd0);
        flag_clear();

        // Strobe sample source
        cfg_samp_sel = 1'b1;
        load(9'h1FF);
        tick(); tick(); tick();
        frc_en = 1'b1; frc_val = 1'b0;
        step(1'b1);
        chk("R7 transfer clock ignored", {31'd0, coll_flag}, 32'd0);
        samp_strobe = 1'b1;
        step(1'b0);
        samp_strobe = 1'b0;
        chk("R7 strobe compares", {31'd0, coll_flag}, 32'd1);
        flag_clear();
        chk("R9 cleared", {31'd0, coll_flag}, 32'd0);
        samp_strobe = 1'b1; coll_clr = 1'b1;
        step(1'b0);
        samp_strobe = 1'b0; coll_clr = 1'b0;
        chk("R9 collision beats clear", {31'd0, coll_flag}, 32'd1);
        frc_en = 1'b0;
        flag_clear();
        en_clr();
        step(1'b1);
        chk("R10 enable loss aborts", {31'd0, busy}, 32'd0);
        step(1'b0);
        cfg_samp_sel = 1'b0;

        // Edge start, normal polarity
        cfg_edge_start = 1'b1;
        load(9'h0F0);
        tick(); tick(); tick();
        chk("R4 transfer clock no start", {31'd0, busy}, 32'd0);
        frc_en = 1'b1; frc_val = 1'b0;
        step(1'b0);
        chk("R5 edge without enable ignored", {31'd0, busy}, 32'd0);
        frc_en = 1'b0;
        step(1'b0);
        en_set();
        tick(); step(1'b0);
        chk("R5 no start without edge", {31'd0, busy}, 32'd0);
        frc_en = 1'b1; frc_val = 1'b0;
        step(1'b0);
        chk("R4 start on falling edge", {30'd0, busy, txd_out}, 32'd2);
        frc_en = 1'b0;
        en_clr();
        step(1'b1);
        step(1'b0);

        // Edge start, inverted polarity: physical rising edge qualifies
        cfg_pol_inv = 1'b1;
        step(1'b0); step(1'b0);
        load(9'h0F0);
        frc_en = 1'b1; frc_val = 1'b1;
        step(1'b0);
        chk("R5 inverted edge without enable", {31'd0, busy}, 32'd0);
        en_set();
        frc_val = 1'b0;
        step(1'b0);
        chk("R4 physical fall ignored when inverted", {31'd0, busy}, 32'd0);
        frc_val = 1'b1;
        step(1'b0);
        chk("R2 R4 start on physical rise", {30'd0, busy, txd_out}, 32'd3);
        frc_en = 1'b0;
        en_clr();
        step(1'b1);
        chk("R2 inverted idle", {30'd0, busy, txd_out}, 32'd0);
        step(1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule